// File: doc/BRIEF.md
# Trace Unit Main Control Register

This block holds the 32-bit main control word of an on-chip trace unit. Two agents can write it: software running on the traced processor, and an external debugger. Each has its own write strobe and data bus, and both share one read port. Static configuration inputs say which optional features exist. A field whose feature is absent reads as zero and ignores writes.

The register also drives the trace unit's control pins. These are power-down, trace-port enable, a debug request with acknowledge handshake, and a FIFO-full stall output gated by a control bit. It decodes its fields into ready-to-use values: the trace port width in pins, the number of context-ID bits traced, the data-access mode and the port clocking mode.

While the power-down bit is set, only the power-down bit and the processor-select field accept writes. Software and the debugger can each lock the other out. A write that asks for data suppression and processor stalling together is refused for those two bits, and an error pulse is raised.

Top module: `trc_ctrl_regfile`

## Requirements
- R1: After synchronous reset the register reads power-down (bit 0) = 1, programming (bit 10) = 1, the port size code {bit 21, bits 6:4} = `cfg_port_min`, and every other bit = 0.
- R2: While bit 0 is 1, an accepted write changes only bit 0 and bits 27:25. Every other bit keeps its value.
- R3: Bits 31 and 29 always read as zero.
- R4: Bit 30 reads zero and ignores writes unless `cfg_has_vmid`. Bit 28 does the same unless `cfg_has_tstamp`. Bit 24 does the same unless `cfg_instr_cnt` is nonzero. Bit 7 does the same unless `cfg_has_stall`.
- R5: Bit 23 (software lockout) can be changed only through the debugger port, and only when `cfg_has_swlock` is set, otherwise it reads zero. While it is 1, software writes are discarded.
- R6: Bit 22 (debugger lockout) can be changed only through the software port, and only when `cfg_has_dbglock` is set, otherwise it reads zero. While it is 1, debugger writes are discarded.
- R7: When both ports strobe in the same cycle, only the debugger write is considered and the software write is dropped.
- R8: An accepted write outside power-down whose masked data sets both bit 18 and bit 7 leaves those two bits at their previous values, updates the other bits, and raises `combo_err` for exactly one cycle, aligned with the register update.
- R9: When bit 9 is 1 and `trig_evt` is high at a clock edge, `dbg_req` is high after that edge. It stays high until an edge where `dbg_ack` is high and no new trigger is enabled, and then it falls.
- R10: `stall_out` equals `fifo_full_in` AND bit 7, registered one cycle. It is low whenever bit 7 was 0 at the previous edge.
- R11: `port_en` equals bit 11 and `pwr_down` equals bit 0.
- R12: `ctx_bits` decodes bits 15:14 as 0→0, 1→8, 2→16, 3→32.
- R13: `port_width` decodes the code {bit 21, bits 6:4} as 0→4, 1→8, 2→16, 3→24, 4→32, 5→48, 6→64, 8→1, 9→2, and any other code → 0. `data_mode` is bits 3:2 and `clk_mode` is {bit 13, bits 17:16}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_wdata | input | 32 | Debugger write data |
| rd_data | output | 32 | Current control word |
| cfg_has_vmid | input | 1 | Virtual-machine ID tracing present |
| cfg_has_tstamp | input | 1 | Timestamping present |
| cfg_instr_cnt | input | INSTR_CNT_W | Number of instrumentation resources |
| cfg_has_swlock | input | 1 | Software lockout bit present |
| cfg_has_dbglock | input | 1 | Debugger lockout bit present |
| cfg_has_stall | input | 1 | FIFO-full stalling present |
| cfg_port_min | input | 4 | Port size code loaded at reset |
| trig_evt | input | 1 | Trigger event |
| dbg_ack | input | 1 | Debug acknowledge from processor |
| fifo_full_in | input | 1 | Internal FIFO nearly full |
| pwr_down | output | 1 | Power-down control pin |
| port_en | output | 1 | Trace port enable pin |
| dbg_req | output | 1 | Debug request to processor |
| stall_out | output | 1 | Processor stall request |
| combo_err | output | 1 | Prohibited suppress/stall write pulse |
| port_width | output | 7 | Decoded trace port width in pins |
| ctx_bits | output | 6 | Decoded context-ID bits traced |
| data_mode | output | 2 | Data-access mode field |
| clk_mode | output | 3 | Port clocking mode field |

## Verification
The hardest situations to reach are the interactions between the gates on a write. A write can arrive while the other agent has locked the port, while the unit is powered down, or with the prohibited suppress/stall pair set, and it can fall under any combination of absent features. The bench sweeps all 64 combinations of the six feature inputs. For each one it drives a pseudo-random stream of software, debugger and simultaneous writes whose data flips the power-down and lockout bits often, so lock-then-unlock, power-down entry and exit, and blocked writes all occur. Every step is compared with an arithmetic reference. Directed sequences then cover the decode tables, the request handshake and the stall gating.

// File: rtl/trc_ctrl_pkg.sv
package trc_ctrl_pkg;
  localparam int CTRL_W  = 32;
  localparam int PW_W    = 7;
  localparam int CTX_W   = 6;
  localparam int PSZ_W   = 4;

  // bit positions whose meaning the decode and gating rely on
  localparam int B_PD      = 0;
  localparam int B_DMODE   = 2;
  localparam int B_PSZ_LO  = 4;
  localparam int B_STALL   = 7;
  localparam int B_DREQ    = 9;
  localparam int B_PROG    = 10;
  localparam int B_PEN     = 11;
  localparam int B_HALF    = 13;
  localparam int B_CTX     = 14;
  localparam int B_PMODE   = 16;
  localparam int B_SUPP    = 18;
  localparam int B_PSZ_HI  = 21;
  localparam int B_DBGLK   = 22;
  localparam int B_SWLK    = 23;
  localparam int B_INSTR   = 24;
  localparam int B_PSEL    = 25;
  localparam int B_TS      = 28;
  localparam int B_RSV_A   = 29;
  localparam int B_VMID    = 30;
  localparam int B_RSV_B   = 31;

  // fields that stay writable during power-down
  localparam logic [CTRL_W-1:0] PD_OPEN = (32'h7 << B_PSEL) | (32'h1 << B_PD);

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_DBG  = 2'd2
  } wr_src_e;

  function automatic logic [PW_W-1:0] psz_to_pins(input logic [PSZ_W-1:0] code);
    logic [PW_W-1:0] r;
    case (code)
      4'd0:    r = 7'd4;
      4'd1:    r = 7'd8;
      4'd2:    r = 7'd16;
      4'd3:    r = 7'd24;
      4'd4:    r = 7'd32;
      4'd5:    r = 7'd48;
      4'd6:    r = 7'd64;
      4'd8:    r = 7'd1;
      4'd9:    r = 7'd2;
      default: r = 7'd0;
    endcase
    return r;
  endfunction

  function automatic logic [CTX_W-1:0] ctx_to_bits(input logic [1:0] code);
    logic [CTX_W-1:0] r;
    if (code == 2'd0) r = '0;
    else              r = CTX_W'(6'd8 << (code - 2'd1));
    return r;
  endfunction
endpackage

// File: rtl/trc_wr_arb.sv
module trc_wr_arb
  import trc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [CTRL_W-1:0] sw_wdata,
  input  logic              dbg_wr,
  input  logic [CTRL_W-1:0] dbg_wdata,
  input  logic              sw_locked,
  input  logic              dbg_locked,
  output logic              wr_en,
  output wr_src_e           wr_src,
  output logic [CTRL_W-1:0] wr_data
);
  always_comb begin
    wr_en   = 1'b0;
    wr_src  = SRC_NONE;
    wr_data = '0;
    if (dbg_wr) begin
      wr_src  = SRC_DBG;
      wr_data = dbg_wdata;
      wr_en   = !dbg_locked;
    end else if (sw_wr) begin
      wr_src  = SRC_SW;
      wr_data = sw_wdata;
      wr_en   = !sw_locked;
    end
  end

  p_dbg_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && dbg_wr) |-> (wr_src == SRC_DBG && wr_data == dbg_wdata));

  p_lock_sw_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_locked && !dbg_wr) |-> !wr_en);

  p_lock_dbg_r6: assert property (@(posedge clk) disable iff (rst)
    (dbg_locked && dbg_wr) |-> !wr_en);
endmodule

// File: rtl/trc_ctrl_reg.sv
module trc_ctrl_reg
  import trc_ctrl_pkg::*;
#(
  parameter int INSTR_CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_has_vmid,
  input  logic                   cfg_has_tstamp,
  input  logic [INSTR_CNT_W-1:0] cfg_instr_cnt,
  input  logic                   cfg_has_swlock,
  input  logic                   cfg_has_dbglock,
  input  logic                   cfg_has_stall,
  input  logic [PSZ_W-1:0]       cfg_port_min,
  input  logic                   wr_en,
  input  wr_src_e                wr_src,
  input  logic [CTRL_W-1:0]      wr_data,
  output logic [CTRL_W-1:0]      ctrl_q,
  output logic                   combo_err
);
  logic [CTRL_W-1:0] impl;
  logic [CTRL_W-1:0] rst_val;
  logic [CTRL_W-1:0] wm;
  logic [CTRL_W-1:0] nxt;
  logic              err_d;

  always_comb begin
    impl          = '1;
    impl[B_RSV_B] = 1'b0;
    impl[B_RSV_A] = 1'b0;
    impl[B_VMID]  = cfg_has_vmid;
    impl[B_TS]    = cfg_has_tstamp;
    impl[B_INSTR] = (cfg_instr_cnt != '0);
    impl[B_SWLK]  = cfg_has_swlock;
    impl[B_DBGLK] = cfg_has_dbglock;
    impl[B_STALL] = cfg_has_stall;
  end

  always_comb begin
    rst_val                       = '0;
    rst_val[B_PD]                 = 1'b1;
    rst_val[B_PROG]               = 1'b1;
    rst_val[B_PSZ_HI]             = cfg_port_min[3];
    rst_val[B_PSZ_LO+2:B_PSZ_LO]  = cfg_port_min[2:0];
  end

  always_comb begin
    nxt   = ctrl_q;
    err_d = 1'b0;
    wm    = wr_data & impl;
    if (wr_en) begin
      if (ctrl_q[B_PD]) begin
        nxt = (ctrl_q & ~PD_OPEN) | (wm & PD_OPEN);
      end else begin
        if (wr_src == SRC_DBG) wm[B_DBGLK] = ctrl_q[B_DBGLK];
        else                   wm[B_SWLK]  = ctrl_q[B_SWLK];
        if (wm[B_SUPP] && wm[B_STALL]) begin
          wm[B_SUPP]  = ctrl_q[B_SUPP];
          wm[B_STALL] = ctrl_q[B_STALL];
          err_d       = 1'b1;
        end
        nxt = wm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= rst_val;
      combo_err <= 1'b0;
    end else begin
      ctrl_q    <= nxt;
      combo_err <= err_d;
    end
  end

  p_pd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_PD] |=> ((ctrl_q & ~PD_OPEN) == ($past(ctrl_q) & ~PD_OPEN)));

  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[B_RSV_B] && !ctrl_q[B_RSV_A]);

  p_no_both_r8: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q[B_SUPP] && ctrl_q[B_STALL]));

  p_err_keep_r8: assert property (@(posedge clk) disable iff (rst)
    combo_err |-> (ctrl_q[B_SUPP] == $past(ctrl_q[B_SUPP]) &&
                   ctrl_q[B_STALL] == $past(ctrl_q[B_STALL])));

  p_feat_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_has_stall |-> !ctrl_q[B_STALL]));
endmodule

// File: rtl/trc_dbgreq_ctl.sv
module trc_dbgreq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req_en,
  input  logic trig_evt,
  input  logic dbg_ack,
  output logic dbg_req
);
  logic fire;
  assign fire = req_en && trig_evt;

  always_ff @(posedge clk) begin
    if (rst)           dbg_req <= 1'b0;
    else if (fire)     dbg_req <= 1'b1;
    else if (dbg_ack)  dbg_req <= 1'b0;
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && !dbg_ack) |=> dbg_req);

  p_req_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (!dbg_req && !(req_en && trig_evt)) |=> !dbg_req);
endmodule

// File: rtl/trc_ctrl_decode.sv
module trc_ctrl_decode
  import trc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PSZ_W-1:0] psz_code,
  input  logic [1:0]       ctx_code,
  input  logic [1:0]       dmode,
  input  logic [2:0]       cmode,
  input  logic             stall_en,
  input  logic             fifo_full_in,
  output logic             stall_out,
  output logic [PW_W-1:0]  port_width,
  output logic [CTX_W-1:0] ctx_bits,
  output logic [1:0]       data_mode,
  output logic [2:0]       clk_mode
);
  always_ff @(posedge clk) begin
    if (rst) stall_out <= 1'b0;
    else     stall_out <= fifo_full_in && stall_en;
  end

  assign port_width = psz_to_pins(psz_code);
  assign ctx_bits   = ctx_to_bits(ctx_code);
  assign data_mode  = dmode;
  assign clk_mode   = cmode;

  p_stall_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !stall_en |=> !stall_out);

  p_stall_follow_r10: assert property (@(posedge clk) disable iff (rst)
    (stall_en && fifo_full_in) |=> stall_out);
endmodule

// File: rtl/trc_ctrl_regfile.sv
module trc_ctrl_regfile
  import trc_ctrl_pkg::*;
#(
  parameter int INSTR_CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sw_wr,
  input  logic [31:0]            sw_wdata,
  input  logic                   dbg_wr,
  input  logic [31:0]            dbg_wdata,
  output logic [31:0]            rd_data,
  input  logic                   cfg_has_vmid,
  input  logic                   cfg_has_tstamp,
  input  logic [INSTR_CNT_W-1:0] cfg_instr_cnt,
  input  logic                   cfg_has_swlock,
  input  logic                   cfg_has_dbglock,
  input  logic                   cfg_has_stall,
  input  logic [3:0]             cfg_port_min,
  input  logic                   trig_evt,
  input  logic                   dbg_ack,
  input  logic                   fifo_full_in,
  output logic                   pwr_down,
  output logic                   port_en,
  output logic                   dbg_req,
  output logic                   stall_out,
  output logic                   combo_err,
  output logic [6:0]             port_width,
  output logic [5:0]             ctx_bits,
  output logic [1:0]             data_mode,
  output logic [2:0]             clk_mode
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_en;
  wr_src_e           wr_src;
  logic [CTRL_W-1:0] wr_data;

  trc_wr_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .sw_wr      (sw_wr),
    .sw_wdata   (sw_wdata),
    .dbg_wr     (dbg_wr),
    .dbg_wdata  (dbg_wdata),
    .sw_locked  (ctrl_q[B_SWLK]),
    .dbg_locked (ctrl_q[B_DBGLK]),
    .wr_en      (wr_en),
    .wr_src     (wr_src),
    .wr_data    (wr_data)
  );

  trc_ctrl_reg #(.INSTR_CNT_W(INSTR_CNT_W)) u_reg (
    .clk             (clk),
    .rst             (rst),
    .cfg_has_vmid    (cfg_has_vmid),
    .cfg_has_tstamp  (cfg_has_tstamp),
    .cfg_instr_cnt   (cfg_instr_cnt),
    .cfg_has_swlock  (cfg_has_swlock),
    .cfg_has_dbglock (cfg_has_dbglock),
    .cfg_has_stall   (cfg_has_stall),
    .cfg_port_min    (cfg_port_min),
    .wr_en           (wr_en),
    .wr_src          (wr_src),
    .wr_data         (wr_data),
    .ctrl_q          (ctrl_q),
    .combo_err       (combo_err)
  );

  trc_dbgreq_ctl u_dreq (
    .clk      (clk),
    .rst      (rst),
    .req_en   (ctrl_q[B_DREQ]),
    .trig_evt (trig_evt),
    .dbg_ack  (dbg_ack),
    .dbg_req  (dbg_req)
  );

  trc_ctrl_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .psz_code     ({ctrl_q[B_PSZ_HI], ctrl_q[B_PSZ_LO+2:B_PSZ_LO]}),
    .ctx_code     (ctrl_q[B_CTX+1:B_CTX]),
    .dmode        (ctrl_q[B_DMODE+1:B_DMODE]),
    .cmode        ({ctrl_q[B_HALF], ctrl_q[B_PMODE+1:B_PMODE]}),
    .stall_en     (ctrl_q[B_STALL]),
    .fifo_full_in (fifo_full_in),
    .stall_out    (stall_out),
    .port_width   (port_width),
    .ctx_bits     (ctx_bits),
    .data_mode    (data_mode),
    .clk_mode     (clk_mode)
  );

  assign rd_data  = ctrl_q;
  assign pwr_down = ctrl_q[B_PD];
  assign port_en  = ctrl_q[B_PEN];
endmodule

// File: tb/trc_ctrl_regfile_tb.sv
`timescale 1ns/1ps
module trc_ctrl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr = 1'b0, dbg_wr = 1'b0;
  logic [31:0] sw_wdata = '0, dbg_wdata = '0;
  logic [31:0] rd_data;
  logic        c_vmid = 1'b1, c_ts = 1'b1, c_swlk = 1'b1, c_dbglk = 1'b1, c_stall = 1'b1;
  logic [3:0]  c_instr = 4'd3;
  logic [3:0]  c_pmin = 4'b0001;
  logic        trig_evt = 1'b0, dbg_ack = 1'b0, fifo_full_in = 1'b0;
  logic        pwr_down, port_en, dbg_req, stall_out, combo_err;
  logic [6:0]  port_width;
  logic [5:0]  ctx_bits;
  logic [1:0]  data_mode;
  logic [2:0]  clk_mode;

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  trc_ctrl_regfile u_dut (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .rd_data(rd_data),
    .cfg_has_vmid(c_vmid), .cfg_has_tstamp(c_ts), .cfg_instr_cnt(c_instr),
    .cfg_has_swlock(c_swlk), .cfg_has_dbglock(c_dbglk), .cfg_has_stall(c_stall),
    .cfg_port_min(c_pmin), .trig_evt(trig_evt), .dbg_ack(dbg_ack),
    .fifo_full_in(fifo_full_in), .pwr_down(pwr_down), .port_en(port_en),
    .dbg_req(dbg_req), .stall_out(stall_out), .combo_err(combo_err),
    .port_width(port_width), .ctx_bits(ctx_bits), .data_mode(data_mode),
    .clk_mode(clk_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    logic [31:0] s = lfsr;
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    s = s ^ (s << 5);
    lfsr = s;
    return s;
  endfunction

  function automatic logic [31:0] feat_mask();
    logic [31:0] m = 32'hFFFF_FFFF;
    m[31] = 1'b0; m[29] = 1'b0;
    m[30] = c_vmid; m[28] = c_ts; m[24] = (c_instr != 0);
    m[23] = c_swlk; m[22] = c_dbglk; m[7] = c_stall;
    return m;
  endfunction

  // reference: state after one write cycle (is_dbg selects the winning port)
  task automatic ref_write(input logic [31:0] old, input bit is_dbg, input logic [31:0] w,
                           output logic [31:0] nv, output bit err);
    logic [31:0] wm = w & feat_mask();
    logic [31:0] open_pd = 32'h0E00_0001;
    err = 1'b0;
    if ((is_dbg && old[22]) || (!is_dbg && old[23])) begin
      nv = old;
    end else if (old[0]) begin
      nv = (old & ~open_pd) | (wm & open_pd);
    end else begin
      if (is_dbg) wm[22] = old[22]; else wm[23] = old[23];
      if (wm[18] && wm[7]) begin
        wm[18] = old[18]; wm[7] = old[7]; err = 1'b1;
      end
      nv = wm;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; sw_wr = 0; dbg_wr = 0; trig_evt = 0; dbg_ack = 0; fifo_full_in = 0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input bit s, input bit d, input logic [31:0] sd, input logic [31:0] dd);
    @(negedge clk);
    sw_wr = s; dbg_wr = d; sw_wdata = sd; dbg_wdata = dd;
    @(posedge clk); #1;
    sw_wr = 0; dbg_wr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [6:0] exp_pins(input logic [3:0] c);
    case (c)
      0: return 7'd4;   1: return 7'd8;   2: return 7'd16;  3: return 7'd24;
      4: return 7'd32;  5: return 7'd48;  6: return 7'd64;  8: return 7'd1;
      9: return 7'd2;   default: return 7'd0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] expv, nv, cw, sd, dd;
    bit          e;
    // feature sweep with reference model
    for (int cfg = 0; cfg < 64; cfg++) begin
      c_vmid = cfg[0]; c_ts = cfg[1]; c_instr = cfg[2] ? 4'd2 : 4'd0;
      c_swlk = cfg[3]; c_dbglk = cfg[4]; c_stall = cfg[5];
      do_reset();
      #1;
      chk("R1 reset word", rd_data, 32'h0000_0411);
      chk("R1 combo_err idle", {31'b0, combo_err}, 32'h0);
      expv = 32'h0000_0411;
      for (int st = 0; st < 24; st++) begin
        cw = nxt_rand(); sd = nxt_rand(); dd = nxt_rand();
        if (st < 2) begin cw[1:0] = 2'b01; sd = 32'hFFFF_FFFE; end
        if (cw[1:0] == 2'b00) cw[0] = 1'b1;
        wr(cw[0], cw[1], sd, dd);
        ref_write(expv, cw[1], cw[1] ? dd : sd, nv, e);
        expv = nv;
        chk("R2/R3/R4/R5/R6/R7 model word", rd_data, expv);
        chk("R8 model err", {31'b0, combo_err}, {31'b0, e});
      end
    end

    // directed, all features on
    c_vmid = 1; c_ts = 1; c_instr = 4'd3; c_swlk = 1; c_dbglk = 1; c_stall = 1;
    do_reset(); #1;
    chk("R11 pwr_down after reset", {31'b0, pwr_down}, 32'h1);
    chk("R11 port_en after reset", {31'b0, port_en}, 32'h0);
    chk("R1 dbg_req after reset", {31'b0, dbg_req}, 32'h0);
    chk("R13 reset port width", {25'b0, port_width}, 32'd8);
    wr(1, 0, 32'hFFFF_FFFF, 0);
    chk("R2 pd write only bit0 and 27:25", rd_data, 32'h0E00_0411);
    wr(1, 0, 32'h0000_0000, 0);
    chk("R2 leave pd", rd_data, 32'h0000_0410);
    chk("R11 pwr_down low", {31'b0, pwr_down}, 32'h0);
    wr(1, 0, 32'hFFFF_FF7E, 0);
    chk("R3 reserved bits zero", rd_data & 32'hA000_0000, 32'h0);
    chk("R4 vmid/ts/instr bits set", rd_data & 32'h5100_0000, 32'h5100_0000);
    chk("R5 sw cannot set swlock", rd_data & 32'h0080_0000, 32'h0);
    chk("R11 port_en high", {31'b0, port_en}, 32'h1);

    do_reset(); wr(1, 0, 0, 0);
    wr(0, 1, 0, 32'h0080_0000);
    chk("R5 debugger sets swlock", rd_data, 32'h0080_0000);
    wr(1, 0, 32'h0000_0800, 0);
    chk("R5 locked sw write discarded", rd_data, 32'h0080_0000);
    wr(0, 1, 0, 32'h0000_0800);
    chk("R5 debugger clears swlock", rd_data, 32'h0000_0800);
    wr(1, 0, 32'h0040_0000, 0);
    chk("R6 software sets dbglock", rd_data, 32'h0040_0000);
    wr(0, 1, 0, 32'h0000_1000);
    chk("R6 locked debugger write discarded", rd_data, 32'h0040_0000);
    wr(1, 0, 32'h0000_0000, 0);
    wr(1, 1, 32'h0000_0800, 32'h0000_1000);
    chk("R7 debugger wins", rd_data, 32'h0000_1000);

    wr(1, 0, 32'h0000_0080, 0);
    wr(1, 0, 32'h0004_0880, 0);
    chk("R8 bits kept, others written", rd_data, 32'h0000_0880);
    chk("R8 err pulse", {31'b0, combo_err}, 32'h1);
    tick();
    chk("R8 err one cycle", {31'b0, combo_err}, 32'h0);

    for (int c = 0; c < 16; c++) begin
      logic [3:0] cc = 4'(c);
      wr(1, 0, ({31'b0, cc[3]} << 21) | ({29'b0, cc[2:0]} << 4), 0);
      chk("R13 port width decode", {25'b0, port_width}, {25'b0, exp_pins(cc)});
    end
    for (int c = 0; c < 4; c++) begin
      wr(1, 0, 32'(c) << 14, 0);
      chk("R12 ctx bits decode", {26'b0, ctx_bits}, (c == 0) ? 32'd0 : (32'd4 << c));
    end
    wr(1, 0, 32'h0002_200C, 0);
    chk("R13 clk_mode", {29'b0, clk_mode}, 32'h6);
    chk("R13 data_mode", {30'b0, data_mode}, 32'h3);

    // debug request handshake
    wr(1, 0, 32'h0000_0000, 0);
    @(negedge clk); trig_evt = 1; tick(); trig_evt = 0;
    chk("R9 no request when disabled", {31'b0, dbg_req}, 32'h0);
    wr(1, 0, 32'h0000_0200, 0);
    @(negedge clk); trig_evt = 1; tick(); trig_evt = 0;
    chk("R9 request raised", {31'b0, dbg_req}, 32'h1);
    tick(); tick(); tick();
    chk("R9 request held", {31'b0, dbg_req}, 32'h1);
    @(negedge clk); dbg_ack = 1; tick(); dbg_ack = 0;
    chk("R9 request dropped on ack", {31'b0, dbg_req}, 32'h0);

    // stall gating
    wr(1, 0, 32'h0000_0080, 0);
    @(negedge clk); fifo_full_in = 1; tick();
    chk("R10 stall follows fifo", {31'b0, stall_out}, 32'h1);
    @(negedge clk); fifo_full_in = 0; tick();
    chk("R10 stall drops", {31'b0, stall_out}, 32'h0);
    wr(1, 0, 32'h0000_0000, 0);
    @(negedge clk); fifo_full_in = 1; tick(); tick();
    chk("R10 stall held low when disabled", {31'b0, stall_out}, 32'h0);
    fifo_full_in = 0;

    // stall feature absent: bit 7 ignored
    c_stall = 0; do_reset(); wr(1, 0, 0, 0);
    wr(1, 0, 32'h0000_0080, 0);
    @(negedge clk); fifo_full_in = 1; tick(); tick();
    chk("R4 stall bit absent reads zero", rd_data, 32'h0);
    chk("R4 stall absent output low", {31'b0, stall_out}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule